// File: doc/BRIEF.md
# Bit-Oriented Code Detector Transmitter

This block carries repeated bit-oriented messages over the 4 kbit/s maintenance data-link bits of an extended superframe (24 frames of 193 bits). Each message is a 16-bit codeword. In the order sent, it holds eight ones, a zero separator, a six-bit code, and a closing zero. The code bits go least-significant bit first. The block does not pull data-link bits out of the superframe itself. Upstream logic hands it one data-link bit per strobe on the receive side, and one transmit slot pulse per data-link bit position on the transmit side.

The receive half searches every bit position for the codeword shape. It counts consecutive identical codewords and latches a code only after a minimum number of repeats, ten by default. It drops the code with a one-cycle idle pulse once two codeword slots in a row fail to carry it. The transmit half sends a programmed code either without end or for a set number of codewords. It always finishes the codeword in progress and drives ones while idle. The all-ones code looks like the flag of message-oriented traffic, so it is never reported and never sent.

Top module: `boc_link`

## Requirements
- R1: The transmitted codeword is 16 bits in this order: bits 0..7 are one, bit 8 is zero, bits 9..14 carry code[0]..code[5] (LSB first), and bit 15 is zero. One bit is emitted per `tx_slot` pulse, and `tx_bit` changes only at a slot.
- R2: `rx_valid` rises, with `rx_code` set to the code, on the strobe that completes the tenth identical consecutive codeword (MIN_REPS = 10). It stays low after only nine.
- R3: Code 6'h3F is never reported on the receive side. A `tx_start` carrying 6'h3F is ignored: `tx_active` stays low and `tx_bit` stays one.
- R4: The receiver finds codewords at any bit offset, including after arbitrary leading bits.
- R5: A codeword that differs from the candidate restarts the repeat count at one.
- R6: While valid, a single codeword slot (16 strobes) without the latched code keeps `rx_valid` high. Two consecutive failing slots clear `rx_valid`, and `rx_idle` pulses for exactly one cycle.
- R7: `rx_code` stays constant while `rx_valid` is high.
- R8: With `tx_reps` = 0 the code repeats until `tx_stop`. After a stop, the current codeword completes and is followed by ones.
- R9: With `tx_reps` = N > 0, exactly N codewords are sent. `tx_active` then falls and `tx_bit` is one at every idle slot.
- R10: A `tx_start` accepted while sending takes effect only at the next codeword boundary.
- R11: After reset, `rx_valid` = 0, `rx_idle` = 0, `tx_bit` = 1 and `tx_active` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received data-link bit |
| rx_strobe | input | 1 | Marks `rx_bit` as a new bit |
| rx_code | output | 6 | Latched validated code |
| rx_valid | output | 1 | Code validated and present |
| rx_idle | output | 1 | One-cycle pulse when the code ends |
| tx_slot | input | 1 | Transmit data-link bit slot |
| tx_start | input | 1 | Load code and repeat count |
| tx_stop | input | 1 | End after the current codeword |
| tx_code_in | input | 6 | Code to send |
| tx_reps | input | 8 | Codewords to send, 0 = continuous |
| tx_bit | output | 1 | Transmitted data-link bit |
| tx_active | output | 1 | A codeword sequence is being sent |

## Verification
A wrong repeat count or candidate shows up at the ports on the strobe that closes the ninth or tenth codeword: `rx_valid` rises one codeword early, late, or not at all. A broken slot-phase or miss counter either keeps `rx_valid` high through 32 silent bits or drops it after 16. A bad word index or boundary decision in the transmitter shows within one 16-slot codeword. In that case a captured word differs from the expected layout, or extra or missing codewords appear before the line returns to ones.

// File: rtl/boc_pkg.sv
package boc_pkg;
  localparam int CODE_W   = 6;
  localparam int HDR_ONES = 8;
  localparam int WORD_LEN = HDR_ONES + 1 + CODE_W + 1;
  localparam int IDX_W    = $clog2(WORD_LEN);

  // Bit at position idx of the codeword carrying code (position 0 sent first)
  function automatic logic word_bit(input logic [CODE_W-1:0] code,
                                    input logic [IDX_W-1:0] idx);
    logic b;
    b = 1'b0;
    if (int'(idx) < HDR_ONES) b = 1'b1;
    for (int i = 0; i < CODE_W; i++)
      if (int'(idx) == HDR_ONES + 1 + i) b = code[i];
    return b;
  endfunction
endpackage

// File: rtl/boc_rx_detect.sv
module boc_rx_detect
  import boc_pkg::*;
#(
  parameter int MIN_REPS   = 10,
  parameter int MISS_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_stb,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              idle_o
);
  localparam int RCW = $clog2(MIN_REPS + 1);
  localparam int MCW = $clog2(MISS_LIMIT + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_LEN - 1);

  logic [WORD_LEN-1:0] sr, sr_nx;
  logic [CODE_W-1:0]   cw, cand;
  logic [RCW-1:0]      rep, rep_n;
  logic [MCW-1:0]      miss;
  logic [IDX_W-1:0]    phase;
  logic                hit, miss_evt, keep_evt;

  always_comb begin
    sr_nx = {sr[WORD_LEN-2:0], bit_in};
    for (int i = 0; i < CODE_W; i++)
      cw[i] = sr_nx[WORD_LEN - 2 - HDR_ONES - i];
    hit = (&sr_nx[WORD_LEN-1 -: HDR_ONES]) && !sr_nx[WORD_LEN-1-HDR_ONES]
          && !sr_nx[0] && (cw != '1);
    if (rep != '0 && cw == cand)
      rep_n = (rep == RCW'(MIN_REPS)) ? rep : rep + RCW'(1);
    else
      rep_n = RCW'(1);
    miss_evt = bit_stb && valid_o &&
               ((hit && cw != code_o) || (!hit && phase == LAST));
    keep_evt = bit_stb && valid_o && hit && cw == code_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; cand <= '0; rep <= '0; miss <= '0; phase <= '0;
      code_o <= '0; valid_o <= 1'b0; idle_o <= 1'b0;
    end else begin
      idle_o <= 1'b0;
      if (bit_stb) begin
        sr <= sr_nx;
        if (hit) begin
          phase <= '0;
          cand  <= cw;
          rep   <= rep_n;
          if (rep_n == RCW'(MIN_REPS) && !valid_o) begin
            valid_o <= 1'b1;
            code_o  <= cw;
          end
        end else if (phase == LAST) begin
          phase <= '0;
          rep   <= '0;
        end else begin
          phase <= phase + IDX_W'(1);
        end
      end
      if (miss_evt) begin
        if (miss == MCW'(MISS_LIMIT - 1)) begin
          valid_o <= 1'b0;
          idle_o  <= 1'b1;
          miss    <= '0;
        end else begin
          miss <= miss + MCW'(1);
        end
      end else if (keep_evt) begin
        miss <= '0;
      end
    end
  end
endmodule

// File: rtl/boc_tx_send.sv
module boc_tx_send
  import boc_pkg::*;
#(
  parameter int REPS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot,
  input  logic              start,
  input  logic              stop,
  input  logic [CODE_W-1:0] code_in,
  input  logic [REPS_W-1:0] reps_in,
  output logic              bit_o,
  output logic              active_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_LEN - 1);

  logic [CODE_W-1:0] cur, pend_code;
  logic [REPS_W-1:0] left, pend_reps;
  logic [IDX_W-1:0]  idx;
  logic              pend_v, stop_req, start_ok;

  assign start_ok = start && (code_in != '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0; pend_code <= '0; left <= '0; pend_reps <= '0; idx <= '0;
      pend_v <= 1'b0; stop_req <= 1'b0; bit_o <= 1'b1; active_o <= 1'b0;
    end else begin
      if (slot) begin
        if (!active_o) begin
          bit_o <= 1'b1;
          if (pend_v) begin
            active_o <= 1'b1;
            cur      <= pend_code;
            left     <= pend_reps;
            pend_v   <= 1'b0;
            idx      <= IDX_W'(1);
          end
        end else begin
          bit_o <= word_bit(cur, idx);
          idx   <= idx + IDX_W'(1);
          if (idx == LAST) begin
            idx <= '0;
            if (pend_v) begin
              cur    <= pend_code;
              left   <= pend_reps;
              pend_v <= 1'b0;
            end else if (stop_req || left == REPS_W'(1)) begin
              active_o <= 1'b0;
              stop_req <= 1'b0;
            end else if (left != '0) begin
              left <= left - REPS_W'(1);
            end
          end
        end
      end
      if (start_ok) begin
        pend_v    <= 1'b1;
        pend_code <= code_in;
        pend_reps <= reps_in;
        stop_req  <= 1'b0;
      end else if (stop) begin
        stop_req <= 1'b1;
        pend_v   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/boc_link.sv
module boc_link
  import boc_pkg::*;
#(
  parameter int MIN_REPS   = 10,
  parameter int MISS_LIMIT = 2,
  parameter int REPS_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              rx_strobe,
  output logic [CODE_W-1:0] rx_code,
  output logic              rx_valid,
  output logic              rx_idle,
  input  logic              tx_slot,
  input  logic              tx_start,
  input  logic              tx_stop,
  input  logic [CODE_W-1:0] tx_code_in,
  input  logic [REPS_W-1:0] tx_reps,
  output logic              tx_bit,
  output logic              tx_active
);
  boc_rx_detect #(.MIN_REPS(MIN_REPS), .MISS_LIMIT(MISS_LIMIT)) rx_i (
    .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_stb(rx_strobe),
    .code_o(rx_code), .valid_o(rx_valid), .idle_o(rx_idle)
  );

  boc_tx_send #(.REPS_W(REPS_W)) tx_i (
    .clk(clk), .rst(rst), .slot(tx_slot), .start(tx_start), .stop(tx_stop),
    .code_in(tx_code_in), .reps_in(tx_reps), .bit_o(tx_bit), .active_o(tx_active)
  );
endmodule

// File: rtl/boc_link_chk.sv
module boc_link_chk
  import boc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] rx_code,
  input logic              rx_valid,
  input logic              rx_idle,
  input logic              tx_slot,
  input logic              tx_bit,
  input logic              tx_active
);
  p_no_allones_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_code != '1);
  p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && $past(rx_valid)) |-> $stable(rx_code));
  p_idle_on_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_valid) |-> rx_idle);
  p_idle_not_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rx_idle |-> !rx_valid);
  p_bit_on_slot_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_slot |=> $stable(tx_bit));
  p_active_on_slot_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_slot |=> $stable(tx_active));
  p_idle_ones_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_slot && !tx_active) |=> tx_bit);
endmodule

bind boc_link boc_link_chk chk_i (
  .clk(clk), .rst(rst), .rx_code(rx_code), .rx_valid(rx_valid),
  .rx_idle(rx_idle), .tx_slot(tx_slot), .tx_bit(tx_bit), .tx_active(tx_active)
);

// File: tb/boc_link_tb_top.sv
module boc_link_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b0, rx_strobe = 1'b0;
  logic [5:0] rx_code;
  logic       rx_valid, rx_idle;
  logic       tx_slot = 1'b0, tx_start = 1'b0, tx_stop = 1'b0;
  logic [5:0] tx_code_in = '0;
  logic [7:0] tx_reps = '0;
  logic       tx_bit, tx_active;

  int checks = 0, fails = 0, idle_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  boc_link dut_i (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_strobe(rx_strobe),
    .rx_code(rx_code), .rx_valid(rx_valid), .rx_idle(rx_idle),
    .tx_slot(tx_slot), .tx_start(tx_start), .tx_stop(tx_stop),
    .tx_code_in(tx_code_in), .tx_reps(tx_reps), .tx_bit(tx_bit), .tx_active(tx_active)
  );

  always @(negedge clk) if (rx_idle) idle_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expw(input logic [5:0] c);
    logic [15:0] v;
    v = 16'h00FF;
    for (int i = 0; i < 6; i++) v[9+i] = c[i];
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_send(input logic b);
    @(negedge clk); rx_bit = b; rx_strobe = 1'b1;
    @(negedge clk); rx_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_word(input logic [5:0] c);
    logic [15:0] w;
    w = expw(c);
    for (int i = 0; i < 16; i++) rx_send(w[i]);
  endtask

  task automatic rx_ones16();
    for (int i = 0; i < 16; i++) rx_send(1'b1);
  endtask

  task automatic tx_take(output logic [15:0] v);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); tx_slot = 1'b1;
      @(negedge clk); tx_slot = 1'b0;
      v[i] = tx_bit;
    end
  endtask

  task automatic tx_take_n(input int n, inout logic [15:0] v, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_slot = 1'b1;
      @(negedge clk); tx_slot = 1'b0;
      v[base+i] = tx_bit;
    end
  endtask

  task automatic tx_go(input logic [5:0] c, input logic [7:0] n);
    @(negedge clk); tx_code_in = c; tx_reps = n; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
    chk(rx_idle == 1'b0, "R11 rx_idle", rx_idle, 0);
    chk(tx_bit == 1'b1, "R11 tx_bit", tx_bit, 1);
    chk(tx_active == 1'b0, "R11 tx_active", tx_active, 0);
  endtask

  task automatic t_rx_accept();
    do_reset();
    rx_send(1'b0); rx_send(1'b1); rx_send(1'b0);  // R4 leading junk
    for (int k = 0; k < 9; k++) rx_word(6'h12);
    chk(rx_valid == 1'b0, "R2 nine reps not valid", rx_valid, 0);
    rx_word(6'h12);
    chk(rx_valid == 1'b1, "R2 R4 tenth rep valid", rx_valid, 1);
    chk(rx_code == 6'h12, "R2 code", rx_code, 6'h12);
    for (int k = 0; k < 3; k++) rx_word(6'h12);
    chk(rx_valid && rx_code == 6'h12, "R7 code held", rx_code, 6'h12);
  endtask

  task automatic t_rx_restart();
    do_reset();
    for (int k = 0; k < 9; k++) rx_word(6'h07);
    rx_word(6'h19);
    for (int k = 0; k < 9; k++) rx_word(6'h07);
    chk(rx_valid == 1'b0, "R5 count restarted", rx_valid, 0);
    rx_word(6'h07);
    chk(rx_valid && rx_code == 6'h07, "R5 valid after ten new", rx_code, 6'h07);
  endtask

  task automatic t_rx_allones();
    do_reset();
    for (int k = 0; k < 12; k++) rx_word(6'h3F);
    chk(rx_valid == 1'b0, "R3 all-ones not reported", rx_valid, 0);
  endtask

  task automatic t_rx_drop();
    int base;
    do_reset();
    for (int k = 0; k < 10; k++) rx_word(6'h21);
    base = idle_cnt;
    rx_ones16();
    chk(rx_valid == 1'b1, "R6 one miss keeps valid", rx_valid, 1);
    rx_word(6'h21);
    rx_ones16();
    chk(rx_valid == 1'b1, "R6 miss reset by good word", rx_valid, 1);
    rx_ones16();
    chk(rx_valid == 1'b0, "R6 two misses clear", rx_valid, 0);
    chk(idle_cnt == base + 1, "R6 idle pulse once", idle_cnt - base, 1);
  endtask

  task automatic t_tx_reps();
    logic [15:0] v;
    do_reset();
    tx_go(6'h05, 8'd2);
    tx_take(v); chk(v == expw(6'h05), "R1 R9 word 1", v, expw(6'h05));
    tx_take(v); chk(v == expw(6'h05), "R9 word 2", v, expw(6'h05));
    chk(tx_active == 1'b0, "R9 inactive after N", tx_active, 0);
    tx_take(v); chk(v == 16'hFFFF, "R9 idle ones", v, 16'hFFFF);
  endtask

  task automatic t_tx_cont();
    logic [15:0] v;
    do_reset();
    tx_go(6'h2A, 8'd0);
    tx_take(v); chk(v == expw(6'h2A), "R8 R1 cont word 1", v, expw(6'h2A));
    tx_take(v); chk(v == expw(6'h2A), "R8 cont word 2", v, expw(6'h2A));
    v = '0;
    tx_take_n(8, v, 0);
    @(negedge clk); tx_stop = 1'b1;
    @(negedge clk); tx_stop = 1'b0;
    tx_take_n(8, v, 8);
    chk(v == expw(6'h2A), "R8 word completes after stop", v, expw(6'h2A));
    tx_take(v); chk(v == 16'hFFFF, "R8 ones after stop", v, 16'hFFFF);
    chk(tx_active == 1'b0, "R8 inactive after stop", tx_active, 0);
  endtask

  task automatic t_tx_switch();
    logic [15:0] v;
    do_reset();
    tx_go(6'h11, 8'd0);
    v = '0;
    tx_take_n(5, v, 0);
    tx_go(6'h0C, 8'd1);
    tx_take_n(11, v, 5);
    chk(v == expw(6'h11), "R10 current word kept", v, expw(6'h11));
    tx_take(v); chk(v == expw(6'h0C), "R10 new code at boundary", v, expw(6'h0C));
    tx_take(v); chk(v == 16'hFFFF, "R10 then idle", v, 16'hFFFF);
  endtask

  task automatic t_tx_allones();
    logic [15:0] v;
    do_reset();
    tx_go(6'h3F, 8'd3);
    tx_take(v); chk(v == 16'hFFFF, "R3 all-ones start ignored", v, 16'hFFFF);
    chk(tx_active == 1'b0, "R3 tx stays inactive", tx_active, 0);
  endtask

  initial begin
    t_reset();
    t_rx_accept();
    t_rx_restart();
    t_rx_allones();
    t_rx_drop();
    t_tx_reps();
    t_tx_cont();
    t_tx_switch();
    t_tx_allones();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule